// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the software-facing register set of a single descriptor-driven DMA channel. It sits on a 32-bit register bus and keeps a 16-bit channel status word and a 32-bit command pointer. It turns the bit changes that software makes in the status word into single-cycle strobes for the channel's command engine: start, abort, resume and pause.

Software never writes the status word directly. Instead it writes the control register. The upper half of that write is a per-bit enable and the lower half is the data, so individual status bits can change without a read-modify-write. The bus carries data in little-endian byte order, so every value is byte-reversed between the bus and the internal word in both directions.

The command engine reports back on two inputs. One marks that the program ended, which clears the active bit. The other marks that the program hit a fault, which sets the dead bit and clears the active bit.

Top module: `dma_chan_regs`

## Requirements
- R1: Only accesses with `busSize` equal to 4 (bytes) take effect. A narrower read returns 0 on `busRData`, and a narrower write changes neither the status word nor the command pointer.
- R2: Bus data is the byte-reversed internal value in both directions. A status read returns `{stat[7:0], stat[15:8], 16'h0000}`. A write value `w` is used internally as `{w[7:0], w[15:8], w[23:16], w[31:24]}`.
- R3: A full write to the control register (word offset 0) takes the internal upper 16 bits as a mask `m` and the lower 16 bits as data `d`. The merged status is `(d & m & 16'hF0FF) | (old & ~m)`. Status bits are run=15, pause=14, flush=13, wake=12, dead=11, active=10, so bits 11:8 can only be cleared through the mask.
- R4: The control register reads as 0. Status (offset 1) is read-only, and writes to it are ignored. Offset 3 reads 0 and ignores writes. The command pointer sits at offset 2.
- R5: If a control write takes run from 0 to 1, active is set, and a start strobe follows unless pause is 1 in the merged status. If run goes from 1 to 0, active and dead are cleared and an abort strobe follows.
- R6: If run is unchanged but wake changes in either direction, active is set and a resume strobe follows.
- R7: If run and wake are unchanged and pause goes from 0 to 1, active is cleared and a pause strobe follows. Pause going from 1 to 0 produces no strobe and leaves active as it was.
- R8: The flush bit is cleared in the same update that would set it, so it never reads back as 1.
- R9: A full write to the command pointer loads it only if run and active are both 0 in the status held before that clock edge. Otherwise the write is dropped.
- R10: Strobes are registered. Each is high for exactly the one cycle after the clock edge that takes the write, and at most one strobe is high at a time.
- R11: `engFault` sets dead and clears active. `engDone` clears active. Both act at the next clock edge and are applied before any control write in the same cycle, so the write sees the updated status as its old value.
- R12: After reset the status word, the command pointer and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Register word offset |
| busSize | input | 3 | Access size in bytes |
| busWData | input | 32 | Write data, bus byte order |
| busRData | output | 32 | Read data, bus byte order, same cycle as the read |
| engDone | input | 1 | Engine reached the end of its program |
| engFault | input | 1 | Engine hit an illegal command |
| chanStatus | output | 16 | Internal status word |
| cmdPtr | output | 32 | Command pointer |
| startPulse | output | 1 | Start the command engine |
| abortPulse | output | 1 | Abort the command engine |
| resumePulse | output | 1 | Resume the command engine |
| pausePulse | output | 1 | Pause the command engine |

## Verification
Read data is combinational, so it is due in the same cycle as the read. The bench samples it one nanosecond after the falling edge on which the read was driven. The status word, the command pointer and the strobes all change at the rising edge that takes the write or the engine report. The bench therefore checks them at the following falling edge, and checks again one cycle later that each strobe has dropped. A behavioural model updated on each rising edge is compared against every output at every falling edge. Directed checks with literal expected values cover the masking, the transition priority, write gating and same-cycle engine reports.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int STAT_W = 16;
  localparam int RUN_BIT = 15;
  localparam int PAUSE_BIT = 14;
  localparam int FLUSH_BIT = 13;
  localparam int WAKE_BIT = 12;
  localparam int DEAD_BIT = 11;
  localparam int ACT_BIT = 10;
  localparam logic [STAT_W-1:0] DATA_KEEP = 16'hF0FF;

  typedef struct packed {
    logic ctrlWr;
    logic ptrWr;
    logic statRd;
    logic setActive;
    logic clrActive;
    logic clrDead;
    logic doStart;
    logic doAbort;
    logic doResume;
    logic doPause;
  } strobeT;

  function automatic logic [31:0] byteRev(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = x[8*(3-i) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int FULL_SIZE = 4,
  parameter logic [ADDR_W-1:0] OFS_CTRL = 0,
  parameter logic [ADDR_W-1:0] OFS_STAT = 1,
  parameter logic [ADDR_W-1:0] OFS_PTR = 2
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic [STAT_W-1:0] heldStat,
  input  logic [STAT_W-1:0] baseStat,
  input  logic [STAT_W-1:0] mergedStat,
  output strobeT            strb
);
  logic fullAcc;
  logic runChg, wakeChg, pauseRise;

  assign fullAcc = busValid && (busSize == 3'(FULL_SIZE));
  assign runChg = mergedStat[RUN_BIT] != baseStat[RUN_BIT];
  assign wakeChg = mergedStat[WAKE_BIT] != baseStat[WAKE_BIT];
  assign pauseRise = mergedStat[PAUSE_BIT] && !baseStat[PAUSE_BIT];

  always_comb begin
    strb = '0;
    strb.statRd = fullAcc && !busWrite && busAddr == OFS_STAT;
    strb.ctrlWr = fullAcc && busWrite && busAddr == OFS_CTRL;
    strb.ptrWr = fullAcc && busWrite && busAddr == OFS_PTR &&
                 !heldStat[RUN_BIT] && !heldStat[ACT_BIT];
    if (strb.ctrlWr) begin
      if (runChg) begin
        if (mergedStat[RUN_BIT]) begin
          strb.setActive = 1'b1;
          strb.doStart = !mergedStat[PAUSE_BIT];
        end else begin
          strb.clrActive = 1'b1;
          strb.clrDead = 1'b1;
          strb.doAbort = 1'b1;
        end
      end else if (wakeChg) begin
        strb.setActive = 1'b1;
        strb.doResume = 1'b1;
      end else if (pauseRise) begin
        strb.clrActive = 1'b1;
        strb.doPause = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       busWData,
  input  logic              engDone,
  input  logic              engFault,
  input  strobeT            strb,
  output logic [STAT_W-1:0] heldStat,
  output logic [STAT_W-1:0] baseStat,
  output logic [STAT_W-1:0] mergedStat,
  output logic [31:0]       busRData,
  output logic [PTR_W-1:0]  cmdPtr,
  output logic [3:0]        pulses
);
  logic [31:0] wordIn;
  logic [STAT_W-1:0] wrMask, wrData, nextStat;
  logic [STAT_W-1:0] statQ;
  logic [PTR_W-1:0] ptrQ;
  logic [3:0] pulseQ;

  assign wordIn = byteRev(busWData);
  assign wrMask = wordIn[31:16];
  assign wrData = wordIn[15:0];

  always_comb begin
    baseStat = statQ;
    if (engFault) baseStat[DEAD_BIT] = 1'b1;
    if (engFault || engDone) baseStat[ACT_BIT] = 1'b0;
  end

  assign mergedStat = (wrData & wrMask & DATA_KEEP) | (baseStat & ~wrMask);

  always_comb begin
    nextStat = baseStat;
    if (strb.ctrlWr) begin
      nextStat = mergedStat;
      if (strb.setActive) nextStat[ACT_BIT] = 1'b1;
      if (strb.clrActive) nextStat[ACT_BIT] = 1'b0;
      if (strb.clrDead) nextStat[DEAD_BIT] = 1'b0;
      nextStat[FLUSH_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= '0;
      ptrQ <= '0;
      pulseQ <= '0;
    end else begin
      statQ <= nextStat;
      if (strb.ptrWr) ptrQ <= wordIn[PTR_W-1:0];
      pulseQ <= {strb.doStart, strb.doAbort, strb.doResume, strb.doPause};
    end
  end

  assign heldStat = statQ;
  assign cmdPtr = ptrQ;
  assign pulses = pulseQ;
  assign busRData = strb.statRd ? byteRev({16'h0000, statQ}) : 32'h0;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int PTR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic [31:0]       busWData,
  output logic [31:0]       busRData,
  input  logic              engDone,
  input  logic              engFault,
  output logic [15:0]       chanStatus,
  output logic [PTR_W-1:0]  cmdPtr,
  output logic              startPulse,
  output logic              abortPulse,
  output logic              resumePulse,
  output logic              pausePulse
);
  strobeT strb;
  logic [STAT_W-1:0] heldStat, baseStat, mergedStat;
  logic [3:0] pulses;

  dma_chan_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .heldStat(heldStat), .baseStat(baseStat),
    .mergedStat(mergedStat), .strb(strb)
  );

  dma_chan_dp #(.PTR_W(PTR_W)) uDp (
    .clk(clk), .rstN(rstN), .busWData(busWData), .engDone(engDone),
    .engFault(engFault), .strb(strb), .heldStat(heldStat),
    .baseStat(baseStat), .mergedStat(mergedStat), .busRData(busRData),
    .cmdPtr(cmdPtr), .pulses(pulses)
  );

  assign chanStatus = heldStat;
  assign startPulse = pulses[3];
  assign abortPulse = pulses[2];
  assign resumePulse = pulses[1];
  assign pausePulse = pulses[0];
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int ADDR_W = 2,
  parameter int PTR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [2:0]        busSize,
  input logic [31:0]       busRData,
  input logic              engDone,
  input logic              engFault,
  input logic [15:0]       chanStatus,
  input logic [PTR_W-1:0]  cmdPtr,
  input logic              startPulse,
  input logic              abortPulse,
  input logic              resumePulse,
  input logic              pausePulse
);
  // R1
  narrow_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busSize != 3'd4 && !engDone && !engFault)
    |=> ($stable(chanStatus) && $stable(cmdPtr)));

  // R1
  narrow_rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busSize != 3'd4) |-> busRData == 32'h0);

  // R4
  stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busSize == 3'd4 && busAddr == ADDR_W'(1) &&
     !engDone && !engFault) |=> $stable(chanStatus));

  // R4
  ctrl_rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr == ADDR_W'(0)) |-> busRData == 32'h0);

  // R8
  flush_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chanStatus[13]);

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startPulse, abortPulse, resumePulse, pausePulse}));

  // R5
  start_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (chanStatus[15] && chanStatus[10] && !chanStatus[14]));

  // R5
  abort_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> (!chanStatus[15] && !chanStatus[10] && !chanStatus[11]));

  // R9
  ptr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmdPtr) |-> $past(!chanStatus[15] && !chanStatus[10]));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) uChk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busSize(busSize), .busRData(busRData),
  .engDone(engDone), .engFault(engFault), .chanStatus(chanStatus),
  .cmdPtr(cmdPtr), .startPulse(startPulse), .abortPulse(abortPulse),
  .resumePulse(resumePulse), .pausePulse(pausePulse)
);

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  logic clk = 0;
  logic rstN = 0;
  logic busValid = 0, busWrite = 0;
  logic [1:0] busAddr = 0;
  logic [2:0] busSize = 0;
  logic [31:0] busWData = 0;
  logic [31:0] busRData;
  logic engDone = 0, engFault = 0;
  logic [15:0] chanStatus;
  logic [31:0] cmdPtr;
  logic startPulse, abortPulse, resumePulse, pausePulse;

  int tests = 0, fails = 0, cycles = 0;
  int mStat = 0, mPtr = 0, mPulse = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_chan_regs uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWData(busWData),
    .busRData(busRData), .engDone(engDone), .engFault(engFault),
    .chanStatus(chanStatus), .cmdPtr(cmdPtr), .startPulse(startPulse),
    .abortPulse(abortPulse), .resumePulse(resumePulse), .pausePulse(pausePulse)
  );

  function automatic logic [31:0] swapB(input logic [31:0] x);
    return {<<8{x}};
  endfunction

  function automatic bit bitOf(input int v, input int b);
    return ((v >> b) & 1) == 1;
  endfunction

  // behavioural reference: pulse code 8=start 4=abort 2=resume 1=pause
  always @(posedge clk) begin
    if (!rstN) begin
      mStat = 0; mPtr = 0; mPulse = 0;
    end else begin
      int s, v, m, d, n, p;
      bit wasIdle;
      wasIdle = !bitOf(mStat, 15) && !bitOf(mStat, 10);
      s = mStat; p = 0;
      if (engFault) s = s | 'h0800;
      if (engFault || engDone) s = s & ~'h0400;
      if (busValid && busWrite && busSize == 3'd4) begin
        v = int'(swapB(busWData));
        if (busAddr == 2'd0) begin
          m = (v >> 16) & 'hFFFF;
          d = v & 'hFFFF;
          n = (d & m & 'hF0FF) | (s & ~m & 'hFFFF);
          if (bitOf(n, 15) != bitOf(s, 15)) begin
            if (bitOf(n, 15)) begin
              n = n | 'h0400;
              if (!bitOf(n, 14)) p = 8;
            end else begin
              n = n & ~'h0C00; p = 4;
            end
          end else if (bitOf(n, 12) != bitOf(s, 12)) begin
            n = n | 'h0400; p = 2;
          end else if (bitOf(n, 14) && !bitOf(s, 14)) begin
            n = n & ~'h0400; p = 1;
          end
          s = n & ~'h2000;
        end else if (busAddr == 2'd2 && wasIdle) begin
          mPtr = v;
        end
      end
      mStat = s; mPulse = p;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always begin
    @(negedge clk); #1;
    if (rstN && !finished) begin
      logic [31:0] expRd;
      expRd = 0;
      if (busValid && !busWrite && busSize == 3'd4 && busAddr == 2'd1)
        expRd = swapB({16'h0, 16'(mStat)});
      check("R3 status model", {16'h0, chanStatus}, 32'(mStat & 'hFFFF));
      check("R9 pointer model", cmdPtr, 32'(mPtr));
      check("R10 strobe model", {28'h0, startPulse, abortPulse, resumePulse, pausePulse},
            32'(mPulse));
      check("R2 read model", busRData, expRd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [2:0] sz, input logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busSize = sz; busWData = d;
    @(negedge clk);
    busValid = 0; busWrite = 0;
    #2;
  endtask

  task automatic rd(input logic [1:0] a, input logic [2:0] sz, output logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a; busSize = sz;
    #2 d = busRData;
    @(negedge clk);
    busValid = 0;
  endtask

  task automatic eng(input bit done, input bit fault);
    @(negedge clk);
    engDone = done; engFault = fault;
    @(negedge clk);
    engDone = 0; engFault = 0;
    #2;
  endtask

  function automatic logic [31:0] pl();
    return {28'h0, startPulse, abortPulse, resumePulse, pausePulse};
  endfunction

  task automatic strobeGone(input string req);
    @(negedge clk); #2;
    check(req, pl(), 32'h0);
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    #2;
    check("R12 reset status", {16'h0, chanStatus}, 32'h0);
    check("R12 reset ptr", cmdPtr, 32'h0);
    check("R12 reset strobes", pl(), 32'h0);
    rstN = 1;

    wr(2'd2, 3'd4, 32'h78563412);
    check("R9 R2 ptr load idle", cmdPtr, 32'h12345678);

    wr(2'd0, 3'd4, 32'h00800080);
    check("R5 run rise status", {16'h0, chanStatus}, 32'h8400);
    check("R5 start strobe", pl(), 32'h8);
    strobeGone("R10 start one cycle");

    wr(2'd2, 3'd4, 32'hEFBEADDE);
    check("R9 ptr write while running dropped", cmdPtr, 32'h12345678);

    rd(2'd1, 3'd4, r);
    check("R2 status read order", r, 32'h00840000);
    rd(2'd0, 3'd4, r);
    check("R4 control reads zero", r, 32'h0);
    rd(2'd1, 3'd2, r);
    check("R1 narrow read zero", r, 32'h0);
    rd(2'd3, 3'd4, r);
    check("R4 unmapped read zero", r, 32'h0);

    wr(2'd0, 3'd2, 32'h00400040);
    check("R1 narrow write ignored", {16'h0, chanStatus}, 32'h8400);
    check("R1 narrow write no strobe", pl(), 32'h0);
    wr(2'd1, 3'd4, 32'hFFFFFFFF);
    check("R4 status write ignored", {16'h0, chanStatus}, 32'h8400);
    wr(2'd3, 3'd4, 32'hFFFFFFFF);
    check("R4 unmapped write ignored", {16'h0, chanStatus}, 32'h8400);

    wr(2'd0, 3'd4, 32'h00100010);
    check("R6 wake status", {16'h0, chanStatus}, 32'h9400);
    check("R6 resume strobe", pl(), 32'h2);

    eng(1, 0);
    check("R11 done clears active", {16'h0, chanStatus}, 32'h9000);

    wr(2'd0, 3'd4, 32'h00400040);
    check("R7 pause status", {16'h0, chanStatus}, 32'hD000);
    check("R7 pause strobe", pl(), 32'h1);

    wr(2'd0, 3'd4, 32'h00200020);
    check("R8 flush self-clears", {16'h0, chanStatus}, 32'hD000);
    check("R8 flush no strobe", pl(), 32'h0);

    eng(0, 1);
    check("R11 fault sets dead", {16'h0, chanStatus}, 32'hD800);

    wr(2'd0, 3'd4, 32'h00000080);
    check("R5 run fall status", {16'h0, chanStatus}, 32'h5000);
    check("R5 abort strobe", pl(), 32'h4);

    wr(2'd0, 3'd4, 32'h00800080);
    check("R5 run rise under pause", {16'h0, chanStatus}, 32'hD400);
    check("R5 start refused under pause", pl(), 32'h0);

    wr(2'd0, 3'd4, 32'h000000C0);
    check("R5 clear run and pause", {16'h0, chanStatus}, 32'h1000);
    check("R5 abort on clear", pl(), 32'h4);

    wr(2'd2, 3'd4, 32'h44332211);
    check("R9 ptr load after stop", cmdPtr, 32'h11223344);

    wr(2'd0, 3'd4, 32'h00800080);
    check("R5 restart", {16'h0, chanStatus}, 32'h9400);
    check("R5 restart strobe", pl(), 32'h8);

    wr(2'd0, 3'd4, 32'h00040004);
    check("R3 masked bit in 11:8 cleared", {16'h0, chanStatus}, 32'h9000);
    check("R3 no strobe", pl(), 32'h0);

    @(negedge clk);
    engFault = 1;
    busValid = 1; busWrite = 1; busAddr = 2'd0; busSize = 3'd4; busWData = 32'h00000010;
    @(negedge clk);
    busValid = 0; busWrite = 0; engFault = 0;
    #2;
    check("R11 fault before wake write", {16'h0, chanStatus}, 32'h8C00);
    check("R11 R6 resume strobe", pl(), 32'h2);

    wr(2'd0, 3'd4, 32'h00400040);
    check("R7 pause set", {16'h0, chanStatus}, 32'hC800);
    wr(2'd0, 3'd4, 32'h00000040);
    check("R7 pause release status", {16'h0, chanStatus}, 32'h8800);
    check("R7 pause release no strobe", pl(), 32'h0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule